// File: doc/BRIEF.md
# PS/2 Key Event Assembler

This block follows a PS/2 byte receiver. Each received byte arrives with a strobe that lasts one cycle. The block turns that byte stream into key events. The two prefix bytes are the extended marker 0xE0 and the break marker 0xF0. Neither prefix produces an event of its own. Each prefix sets a sticky flag, and that flag travels with the next byte that is not a prefix. Any byte that is not a prefix is a key code. A key code produces one registered event, which carries the code and both collected flags. After the key code, both flags are cleared.

The block also follows the state of the two shift keys and drives a level that is high while either shift key is held down. A build-time switch controls how shift keys are reported. When the switch is set, shift makes and shift breaks update only the shift level and produce no event. When the switch is clear, shift keys produce ordinary events, and the level is still maintained.

Top module: `ps2_evt_decoder`

## Requirements
- R1: A byte 0xE0 received with `byte_valid` produces no event. It sets the extended indication for the next key code.
- R2: A byte 0xF0 received with `byte_valid` produces no event. It sets the break indication for the next key code.
- R3: Any other received byte is a key code. It raises `evt_valid` in the cycle after its strobe. In that cycle `evt_code` equals the byte, and `evt_ext` and `evt_brk` show whether 0xE0 and 0xF0 were received since the previous key code. Prefix order and repetition do not matter.
- R4: `evt_valid` is high for exactly one cycle per event and is low in every other cycle. `evt_code`, `evt_ext` and `evt_brk` hold their last values between events.
- R5: Both held prefix indications are cleared after every key code. This includes a shift code that was suppressed.
- R6: Left shift is code 0x12 and right shift is code 0x59. A make code marks that key as held down. A code preceded by 0xF0 marks it as released. `shift_on` is high while either key is held. It changes at the same edge as the event and never in a cycle without a strobed byte.
- R7: The codes 0x12 and 0x59 preceded by 0xE0 are not shift keys. They leave `shift_on` unchanged and are always reported as events.
- R8: With `TRAP_SHIFT`=1, shift codes that are not extended produce no event. With `TRAP_SHIFT`=0, they produce normal events.
- R9: A synchronous active-high `rst` clears both prefix indications, both shift states and `evt_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | KC_W | Received byte |
| evt_valid | output | 1 | One-cycle key event strobe |
| evt_code | output | KC_W | Key code of the event |
| evt_ext | output | 1 | Event was preceded by the extended prefix |
| evt_brk | output | 1 | Event is a key release |
| shift_on | output | 1 | Either shift key is held down |

## Verification
The bench attacks these corner cases:
- **Stacked and repeated prefixes.** A design that cleared a flag when the second prefix arrived would report a break without the extended bit.
- **Suppressed shift code followed by an ordinary key.** A design that failed to clear its flags after a suppressed code would report the ordinary key as a release.
- **Extended 0x12.** A design that treated this code as a shift key would change `shift_on`, or would drop the event in trap mode.
- **Overlapping left and right shift.** A design that used a single shift bit would drop `shift_on` while the second key is still held.
- **Reset in the middle of a sequence.** A design that did not clear the pending prefix would leak it into the first event after reset.

// File: rtl/ps2_evt_pkg.sv
package ps2_evt_pkg;
  localparam int unsigned KC_W_DEF    = 8;
  localparam logic [7:0]  EXT_PFX_DEF = 8'hE0;
  localparam logic [7:0]  BRK_PFX_DEF = 8'hF0;
  localparam logic [7:0]  LSHIFT_DEF  = 8'h12;
  localparam logic [7:0]  RSHIFT_DEF  = 8'h59;
  localparam int unsigned NUM_SHIFT   = 2;
endpackage

// File: rtl/ps2_pfx_hold.sv
module ps2_pfx_hold #(
  parameter int unsigned     KC_W    = 8,
  parameter logic [KC_W-1:0] EXT_PFX = 8'hE0,
  parameter logic [KC_W-1:0] BRK_PFX = 8'hF0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            byte_valid,
  input  logic [KC_W-1:0] byte_data,
  output logic            code_stb,
  output logic            ext_held,
  output logic            brk_held
);
  logic is_ext, is_brk;

  assign is_ext   = (byte_data == EXT_PFX);
  assign is_brk   = (byte_data == BRK_PFX);
  assign code_stb = byte_valid && !is_ext && !is_brk;

  // Prefixes are sticky; any key code consumes and clears them.
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_held <= 1'b0;
      brk_held <= 1'b0;
    end else if (byte_valid) begin
      if (is_ext) begin
        ext_held <= 1'b1;
      end else if (is_brk) begin
        brk_held <= 1'b1;
      end else begin
        ext_held <= 1'b0;
        brk_held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ps2_shift_track.sv
module ps2_shift_track #(
  parameter int unsigned              KC_W      = 8,
  parameter int unsigned              NUM_KEYS  = 2,
  parameter logic [NUM_KEYS*KC_W-1:0] KEY_CODES = 16'h5912
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            code_stb,
  input  logic [KC_W-1:0] code,
  input  logic            ext_held,
  input  logic            brk_held,
  output logic            key_hit,
  output logic            shift_on
);
  logic [NUM_KEYS-1:0] hit;
  logic [NUM_KEYS-1:0] down_q;

  for (genvar i = 0; i < NUM_KEYS; i++) begin : g_key
    assign hit[i] = code_stb && !ext_held && (code == KEY_CODES[i*KC_W +: KC_W]);

    always_ff @(posedge clk) begin
      if (rst) begin
        down_q[i] <= 1'b0;
      end else if (hit[i]) begin
        down_q[i] <= !brk_held;
      end
    end
  end

  assign key_hit  = |hit;
  assign shift_on = |down_q;
endmodule

// File: rtl/ps2_evt_out.sv
module ps2_evt_out #(
  parameter int unsigned KC_W       = 8,
  parameter bit          TRAP_SHIFT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            code_stb,
  input  logic [KC_W-1:0] code,
  input  logic            ext_held,
  input  logic            brk_held,
  input  logic            key_hit,
  output logic            evt_valid,
  output logic [KC_W-1:0] evt_code,
  output logic            evt_ext,
  output logic            evt_brk
);
  logic fire;

  assign fire = code_stb && !(TRAP_SHIFT && key_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid <= 1'b0;
      evt_code  <= '0;
      evt_ext   <= 1'b0;
      evt_brk   <= 1'b0;
    end else begin
      evt_valid <= fire;
      if (fire) begin
        evt_code <= code;
        evt_ext  <= ext_held;
        evt_brk  <= brk_held;
      end
    end
  end
endmodule

// File: rtl/ps2_evt_decoder.sv
module ps2_evt_decoder #(
  parameter int unsigned     KC_W       = ps2_evt_pkg::KC_W_DEF,
  parameter logic [KC_W-1:0] EXT_PFX    = KC_W'(ps2_evt_pkg::EXT_PFX_DEF),
  parameter logic [KC_W-1:0] BRK_PFX    = KC_W'(ps2_evt_pkg::BRK_PFX_DEF),
  parameter logic [KC_W-1:0] L_SHIFT    = KC_W'(ps2_evt_pkg::LSHIFT_DEF),
  parameter logic [KC_W-1:0] R_SHIFT    = KC_W'(ps2_evt_pkg::RSHIFT_DEF),
  parameter bit              TRAP_SHIFT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            byte_valid,
  input  logic [KC_W-1:0] byte_data,
  output logic            evt_valid,
  output logic [KC_W-1:0] evt_code,
  output logic            evt_ext,
  output logic            evt_brk,
  output logic            shift_on
);
  localparam int unsigned NKEY = ps2_evt_pkg::NUM_SHIFT;
  localparam logic [NKEY*KC_W-1:0] SHIFT_CODES = {R_SHIFT, L_SHIFT};

  logic code_stb, ext_held, brk_held, key_hit;

  ps2_pfx_hold #(
    .KC_W(KC_W), .EXT_PFX(EXT_PFX), .BRK_PFX(BRK_PFX)
  ) u_pfx (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .code_stb(code_stb), .ext_held(ext_held), .brk_held(brk_held)
  );

  ps2_shift_track #(
    .KC_W(KC_W), .NUM_KEYS(NKEY), .KEY_CODES(SHIFT_CODES)
  ) u_shift (
    .clk(clk), .rst(rst), .code_stb(code_stb), .code(byte_data),
    .ext_held(ext_held), .brk_held(brk_held),
    .key_hit(key_hit), .shift_on(shift_on)
  );

  ps2_evt_out #(
    .KC_W(KC_W), .TRAP_SHIFT(TRAP_SHIFT)
  ) u_out (
    .clk(clk), .rst(rst), .code_stb(code_stb), .code(byte_data),
    .ext_held(ext_held), .brk_held(brk_held), .key_hit(key_hit),
    .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_ext(evt_ext), .evt_brk(evt_brk)
  );
endmodule

// File: rtl/ps2_evt_decoder_chk.sv
module ps2_evt_decoder_chk #(
  parameter int unsigned     KC_W    = 8,
  parameter logic [KC_W-1:0] EXT_PFX = 8'hE0,
  parameter logic [KC_W-1:0] BRK_PFX = 8'hF0,
  parameter logic [KC_W-1:0] L_SHIFT = 8'h12,
  parameter logic [KC_W-1:0] R_SHIFT = 8'h59
) (
  input logic            clk,
  input logic            rst,
  input logic            byte_valid,
  input logic [KC_W-1:0] byte_data,
  input logic            evt_valid,
  input logic [KC_W-1:0] evt_code,
  input logic            evt_ext,
  input logic            evt_brk,
  input logic            shift_on
);
  logic plain_key;
  assign plain_key = byte_valid && byte_data != EXT_PFX && byte_data != BRK_PFX &&
                     byte_data != L_SHIFT && byte_data != R_SHIFT;

  AST_EXT_SILENT:   assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data == EXT_PFX) |=> !evt_valid); // R1
  AST_BRK_SILENT:   assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data == BRK_PFX) |=> !evt_valid); // R2
  AST_PLAIN_EVENT:  assert property (@(posedge clk) disable iff (rst)
    plain_key |=> (evt_valid && evt_code == $past(byte_data))); // R3
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> $past(byte_valid)); // R4
  AST_HOLD_FIELDS:  assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> ($stable(evt_code) && $stable(evt_ext) && $stable(evt_brk))); // R4
  AST_SHIFT_QUIET:  assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> $stable(shift_on)); // R6
  AST_RESET_STATE:  assert property (@(posedge clk)
    rst |=> (!evt_valid && !shift_on)); // R9
endmodule

bind ps2_evt_decoder ps2_evt_decoder_chk #(
  .KC_W(KC_W), .EXT_PFX(EXT_PFX), .BRK_PFX(BRK_PFX),
  .L_SHIFT(L_SHIFT), .R_SHIFT(R_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
  .evt_valid(evt_valid), .evt_code(evt_code), .evt_ext(evt_ext),
  .evt_brk(evt_brk), .shift_on(shift_on)
);

// File: tb/ps2_evt_decoder_tb.sv
module ps2_evt_decoder_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;

  logic       t_v, t_e, t_b, t_s;
  logic [7:0] t_c;
  logic       o_v, o_e, o_b, o_s;
  logic [7:0] o_c;

  int n_chk = 0;
  int n_err = 0;

  // model state
  logic m_ext = 0, m_brk = 0, m_l = 0, m_r = 0;
  logic [7:0] t_last = 0, o_last = 0;
  logic t_le = 0, t_lb = 0, o_le = 0, o_lb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_evt_decoder #(.TRAP_SHIFT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .evt_valid(t_v), .evt_code(t_c), .evt_ext(t_e), .evt_brk(t_b), .shift_on(t_s));

  ps2_evt_decoder #(.TRAP_SHIFT(1'b0)) u_dut_open (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .evt_valid(o_v), .evt_code(o_c), .evt_ext(o_e), .evt_brk(o_b), .shift_on(o_s));

  function automatic logic is_pfx(input logic [7:0] d);
    return d == 8'hE0 || d == 8'hF0;
  endfunction

  function automatic logic is_shift(input logic [7:0] d, input logic ext);
    return !ext && (d == 8'h12 || d == 8'h59);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_held(input string tag);
    chk({tag, " trap code"}, t_c, t_last);
    chk({tag, " trap ext"},  t_e, t_le);
    chk({tag, " trap brk"},  t_b, t_lb);
    chk({tag, " open code"}, o_c, o_last);
    chk({tag, " open ext"},  o_e, o_le);
    chk({tag, " open brk"},  o_b, o_lb);
  endtask

  task automatic send(input logic [7:0] d);
    logic pfx, sh, ev_o, ev_t;
    string tag;
    pfx  = is_pfx(d);
    sh   = is_shift(d, m_ext);
    ev_o = !pfx;
    ev_t = !pfx && !sh;
    if (d == 8'hE0) tag = "R1";
    else if (d == 8'hF0) tag = "R2";
    else if (sh) tag = "R8";
    else tag = "R3";
    if (ev_t) begin t_last = d; t_le = m_ext; t_lb = m_brk; end
    if (ev_o) begin o_last = d; o_le = m_ext; o_lb = m_brk; end
    if (d == 8'hE0) m_ext = 1;
    else if (d == 8'hF0) m_brk = 1;
    else begin
      if (sh && d == 8'h12) m_l = !m_brk;
      if (sh && d == 8'h59) m_r = !m_brk;
      m_ext = 0;
      m_brk = 0; // R5
    end
    byte_valid = 1'b1;
    byte_data  = d;
    @(negedge clk);
    byte_valid = 1'b0;
    chk({tag, " trap valid"}, t_v, ev_t);
    chk({tag, " open valid"}, o_v, ev_o);
    check_held(tag);
    chk("R6 trap shift_on", t_s, m_l | m_r);
    chk("R6 open shift_on", o_s, m_l | m_r);
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R4 trap idle valid", t_v, 0);
    chk("R4 open idle valid", o_v, 0);
    check_held("R4 held");
    chk("R6 idle shift", t_s, m_l | m_r);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 trap valid", t_v, 0);
    chk("R9 open valid", o_v, 0);
    chk("R9 trap shift", t_s, 0);
    chk("R9 open shift", o_s, 0);
    m_ext = 0; m_brk = 0; m_l = 0; m_r = 0;
    t_last = 0; t_le = 0; t_lb = 0;
    o_last = 0; o_le = 0; o_lb = 0;
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();
    // R1 / R2: lone prefixes, then stacked and repeated prefixes on a key
    send(8'hE0); idle();
    send(8'hF0); send(8'h11);           // R3 ext+brk
    send(8'hF0); send(8'hF0); send(8'h1C);
    send(8'h11);                        // R3 plain alt, no ext
    send(8'hE0); send(8'h11);           // R3 right alt with ext
    // R6: overlapping shifts
    send(8'h12); send(8'h59);
    send(8'hF0); send(8'h12); idle();   // right still down
    send(8'hF0); send(8'h59);
    // R5: trapped shift break then ordinary key carries no flags
    send(8'h12); send(8'hF0); send(8'h12); send(8'h2B);
    // R7: extended 0x12 is not a shift key
    send(8'hE0); send(8'h12);
    send(8'hE0); send(8'hF0); send(8'h59);
    // R9: reset in the middle of a pending prefix with shift held
    send(8'h59); send(8'hE0);
    do_reset();
    send(8'h1C);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 12;
      if (r < 2) send(8'hE0);
      else if (r < 4) send(8'hF0);
      else if (r == 4) send(8'h12);
      else if (r == 5) send(8'h59);
      else if (r == 6) idle();
      else send(8'($urandom));
    end
    idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule